// File: doc/BRIEF.md
# Barrel Shifter with Carry and Flag Update

This block is a single-cycle 32-bit shifter that sits beside an ALU. It performs a logical left shift, a logical right shift, an arithmetic right shift or a rotate right on one operand. It also produces the next sign, zero, carry and overflow flags. The shift distance comes from one of two places: a 5-bit constant taken from the instruction word, or the low byte of a second register. Because of the second source, a distance can be anywhere from 0 to 255, and the carry flag has a defined value at every distance.

The shift datapath has no clock. A small flags register with a write enable sits next to it and captures the next flags when asked. The overflow flag is never computed here: the incoming value is copied through. Instruction decoding and the register file belong to neighbouring blocks.

Top module: `shift_unit`

## Requirements
- R1: When `use_reg_amt_i` is 1, the distance is `reg_amt_i[7:0]` and bits 31..8 have no effect. When it is 0, the distance is `imm_amt_i` (0..31).
- R2: Kind 2'b00 (logical left) fills the vacated low bits with 0. For a distance of 1..31, C is the last bit pushed out of the top, which is `operand_i[32-distance]`.
- R3: Kind 2'b01 (logical right) fills the vacated high bits with 0. For a distance of 1..31, C is `operand_i[distance-1]`.
- R4: Kind 2'b10 (arithmetic right) copies bit 31 into the vacated high bits. For a distance of 1..31, C is `operand_i[distance-1]`.
- R5: Kind 2'b11 (rotate right) turns by the distance mod 32. For any nonzero distance, C equals bit 31 of the result. A nonzero multiple of 32 returns the operand unchanged, with C equal to operand bit 31.
- R6: A distance of 0 returns the operand unchanged and passes `carry_i` to C, for every kind.
- R7: For a logical shift by exactly 32, the result is 0 and C is operand bit 0 (left) or bit 31 (right). Above 32, both the result and C are 0.
- R8: For an arithmetic right shift by 32 or more, every result bit and C equal operand bit 31.
- R9: `nzcv_o` is {N, Z, C, V} in bits 3..0. N is result bit 31, Z is 1 when the result is zero, and V equals `ovf_i`.
- R10: `flags_q_o` clears to 0 on reset. It loads `nzcv_o` on a rising clock edge when `flags_we_i` is 1, and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock for the flags register |
| rst_ni | input | 1 | Active-low asynchronous reset |
| operand_i | input | 32 | Value to shift |
| kind_i | input | 2 | 00 left, 01 logical right, 10 arithmetic right, 11 rotate right |
| use_reg_amt_i | input | 1 | 1 selects the register distance, 0 the immediate |
| imm_amt_i | input | 5 | Immediate distance |
| reg_amt_i | input | 32 | Register holding the distance in its low byte |
| carry_i | input | 1 | Current carry flag |
| ovf_i | input | 1 | Current overflow flag |
| flags_we_i | input | 1 | Load the flags register |
| result_o | output | 32 | Shifted value |
| nzcv_o | output | 4 | Next flags {N,Z,C,V} |
| flags_q_o | output | 4 | Registered flags {N,Z,C,V} |

## Verification
The flag capture and the zero-distance carry pass-through can happen in the same cycle. In that case the carry the register loads comes straight from `carry_i`, not from the shifter. The bench sets up this overlap by raising `flags_we_i` while the register distance is 0 and `carry_i` is 1. It then confirms that the stored C is 1 and that N and Z follow the unchanged operand. A second capture at a distance of 33 checks that the stored C drops to 0 in the same way.

// File: rtl/shift_pkg.sv
package shift_pkg;
  typedef enum logic [1:0] {
    SH_LSL = 2'd0,
    SH_LSR = 2'd1,
    SH_ASR = 2'd2,
    SH_ROR = 2'd3
  } shift_kind_e;
endpackage

// File: rtl/shift_amt_sel.sv
module shift_amt_sel #(
  parameter int IMM_W = 5,
  parameter int AMT_W = 8,
  parameter int REG_W = 32
) (
  input  logic             use_reg_i,
  input  logic [IMM_W-1:0] imm_i,
  input  logic [REG_W-1:0] reg_i,
  output logic [AMT_W-1:0] amt_o
);
  localparam int PAD_W = AMT_W - IMM_W;

  logic [REG_W-AMT_W-1:0] unused_hi;
  assign unused_hi = reg_i[REG_W-1:AMT_W];  // high register bits are don't-care

  assign amt_o = use_reg_i ? reg_i[AMT_W-1:0] : {{PAD_W{1'b0}}, imm_i};
endmodule

// File: rtl/shift_core.sv
module shift_core
  import shift_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int AMT_W = 8
) (
  input  logic [WIDTH-1:0] op_i,
  input  shift_kind_e      kind_i,
  input  logic [AMT_W-1:0] amt_i,
  input  logic             carry_i,
  output logic [WIDTH-1:0] res_o,
  output logic             carry_o
);
  localparam int SHW = $clog2(WIDTH);
  localparam logic [AMT_W-1:0] FULL = AMT_W'(WIDTH);

  logic [SHW-1:0]   sa, sa_m1, sa_neg;
  logic             is_zero, in_range, is_full;
  logic [WIDTH-1:0] rot;

  assign sa       = amt_i[SHW-1:0];
  assign sa_m1    = sa - 1'b1;
  assign sa_neg   = '0 - sa;  // WIDTH - sa, modulo WIDTH
  assign is_zero  = (amt_i == '0);
  assign in_range = (amt_i < FULL);
  assign is_full  = (amt_i == FULL);
  assign rot      = (op_i >> sa) | (op_i << sa_neg);

  always_comb begin
    res_o   = op_i;
    carry_o = carry_i;
    if (!is_zero) begin
      unique case (kind_i)
        SH_LSL: begin
          if (in_range) begin
            res_o   = op_i << sa;
            carry_o = op_i[sa_neg];
          end else begin
            res_o   = '0;
            carry_o = is_full & op_i[0];
          end
        end
        SH_LSR: begin
          if (in_range) begin
            res_o   = op_i >> sa;
            carry_o = op_i[sa_m1];
          end else begin
            res_o   = '0;
            carry_o = is_full & op_i[WIDTH-1];
          end
        end
        SH_ASR: begin
          if (in_range) begin
            res_o   = $unsigned($signed(op_i) >>> sa);
            carry_o = op_i[sa_m1];
          end else begin
            res_o   = {WIDTH{op_i[WIDTH-1]}};
            carry_o = op_i[WIDTH-1];
          end
        end
        default: begin
          res_o   = rot;
          carry_o = rot[WIDTH-1];
        end
      endcase
    end
  end
endmodule

// File: rtl/shift_flags_reg.sv
module shift_flags_reg #(
  parameter int FLAG_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [FLAG_W-1:0] d_i,
  output logic [FLAG_W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (we_i) q_o <= d_i;
  end
endmodule

// File: rtl/shift_unit.sv
module shift_unit
  import shift_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int IMM_W = $clog2(WIDTH),
  parameter int AMT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] operand_i,
  input  logic [1:0]       kind_i,
  input  logic             use_reg_amt_i,
  input  logic [IMM_W-1:0] imm_amt_i,
  input  logic [WIDTH-1:0] reg_amt_i,
  input  logic             carry_i,
  input  logic             ovf_i,
  input  logic             flags_we_i,
  output logic [WIDTH-1:0] result_o,
  output logic [3:0]       nzcv_o,
  output logic [3:0]       flags_q_o
);
  localparam int SHW = $clog2(WIDTH);
  localparam logic [AMT_W-1:0] FULL = AMT_W'(WIDTH);

  logic [AMT_W-1:0] amt;
  logic             c_next;

  shift_amt_sel #(.IMM_W(IMM_W), .AMT_W(AMT_W), .REG_W(WIDTH)) i_amt_sel (
    .use_reg_i (use_reg_amt_i),
    .imm_i     (imm_amt_i),
    .reg_i     (reg_amt_i),
    .amt_o     (amt)
  );

  shift_core #(.WIDTH(WIDTH), .AMT_W(AMT_W)) i_core (
    .op_i    (operand_i),
    .kind_i  (shift_kind_e'(kind_i)),
    .amt_i   (amt),
    .carry_i (carry_i),
    .res_o   (result_o),
    .carry_o (c_next)
  );

  assign nzcv_o = {result_o[WIDTH-1], ~|result_o, c_next, ovf_i};

  shift_flags_reg #(.FLAG_W(4)) i_flags (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (flags_we_i),
    .d_i    (nzcv_o),
    .q_o    (flags_q_o)
  );

  // R6
  zero_amt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (amt == '0) |-> (result_o == operand_i && nzcv_o[1] == carry_i));

  // R5
  ror_mult_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kind_i == 2'd3 && amt != '0 && amt[SHW-1:0] == '0)
      |-> (result_o == operand_i && nzcv_o[1] == operand_i[WIDTH-1]));

  // R7
  logic_over_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kind_i[1] == 1'b0 && amt > FULL) |-> (result_o == '0 && !nzcv_o[1]));

  // R8
  asr_sat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kind_i == 2'd2 && amt >= FULL)
      |-> (result_o == {WIDTH{operand_i[WIDTH-1]}} && nzcv_o[1] == operand_i[WIDTH-1]));

  // R10
  flag_cap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flags_we_i |=> (flags_q_o == $past(nzcv_o)));

  // R10
  flag_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flags_we_i |=> $stable(flags_q_o));

  // R9
  ovf_copy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flags_we_i |=> (flags_q_o[0] == $past(ovf_i)));
endmodule

// File: tb/test_shift_unit.sv
module test_shift_unit;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] operand_i = '0;
  logic [1:0]  kind_i = '0;
  logic        use_reg_amt_i = 1'b0;
  logic [4:0]  imm_amt_i = '0;
  logic [31:0] reg_amt_i = '0;
  logic        carry_i = 1'b0;
  logic        ovf_i = 1'b0;
  logic        flags_we_i = 1'b0;
  logic [31:0] result_o;
  logic [3:0]  nzcv_o;
  logic [3:0]  flags_q_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  shift_unit i_shift_unit (
    .clk_i, .rst_ni, .operand_i, .kind_i, .use_reg_amt_i, .imm_amt_i,
    .reg_amt_i, .carry_i, .ovf_i, .flags_we_i, .result_o, .nzcv_o, .flags_q_o
  );

  typedef struct packed {
    logic [1:0]  kind;
    logic        use_reg;
    logic [4:0]  imm;
    logic [31:0] ramt;
    logic [31:0] op;
    logic        cin;
    logic [31:0] res;
    logic        c;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 1'b0, 5'd1,  32'h0,          32'h8000_0001, 1'b0, 32'h0000_0002, 1'b1}, // R2
    '{2'd0, 1'b0, 5'd31, 32'h0,          32'h0000_0003, 1'b0, 32'h8000_0000, 1'b1}, // R2
    '{2'd0, 1'b0, 5'd0,  32'h0,          32'h8000_0001, 1'b1, 32'h8000_0001, 1'b1}, // R6
    '{2'd0, 1'b1, 5'd0,  32'd32,         32'h0000_0001, 1'b0, 32'h0,         1'b1}, // R7
    '{2'd0, 1'b1, 5'd0,  32'd33,         32'hFFFF_FFFF, 1'b1, 32'h0,         1'b0}, // R7
    '{2'd1, 1'b0, 5'd4,  32'h0,          32'h0000_00F8, 1'b0, 32'h0000_000F, 1'b1}, // R3
    '{2'd1, 1'b1, 5'd0,  32'd32,         32'h8000_0000, 1'b0, 32'h0,         1'b1}, // R7
    '{2'd1, 1'b1, 5'd0,  32'd200,        32'hFFFF_FFFF, 1'b1, 32'h0,         1'b0}, // R7
    '{2'd2, 1'b0, 5'd4,  32'h0,          32'h8000_0010, 1'b1, 32'hF800_0001, 1'b0}, // R4
    '{2'd2, 1'b1, 5'd0,  32'd40,         32'h8000_0000, 1'b0, 32'hFFFF_FFFF, 1'b1}, // R8
    '{2'd2, 1'b1, 5'd0,  32'd255,        32'h7FFF_FFFF, 1'b1, 32'h0,         1'b0}, // R8
    '{2'd2, 1'b1, 5'd0,  32'd32,         32'h8000_0000, 1'b0, 32'hFFFF_FFFF, 1'b1}, // R8
    '{2'd3, 1'b0, 5'd8,  32'h0,          32'h1234_5678, 1'b1, 32'h7812_3456, 1'b0}, // R5
    '{2'd3, 1'b1, 5'd0,  32'd64,         32'h8000_0001, 1'b0, 32'h8000_0001, 1'b1}, // R5
    '{2'd3, 1'b1, 5'd0,  32'd33,         32'h0000_0001, 1'b0, 32'h8000_0000, 1'b1}, // R5
    '{2'd3, 1'b0, 5'd0,  32'h0,          32'h0000_0000, 1'b1, 32'h0,         1'b1}, // R6
    '{2'd1, 1'b1, 5'd9,  32'h0000_0104,  32'h0000_00F8, 1'b0, 32'h0000_000F, 1'b1}, // R1
    '{2'd0, 1'b1, 5'd9,  32'hFFFF_FF00,  32'h1234_5678, 1'b0, 32'h1234_5678, 1'b0}, // R1
    '{2'd1, 1'b0, 5'd2,  32'h0000_0004,  32'h0000_00F8, 1'b1, 32'h0000_003E, 1'b0}, // R1
    '{2'd2, 1'b1, 5'd0,  32'hABCD_EF00,  32'hC000_0000, 1'b1, 32'hC000_0000, 1'b1}  // R1 R6
  };

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(vec_t v, logic ovf);
    kind_i        = v.kind;
    use_reg_amt_i = v.use_reg;
    imm_amt_i     = v.imm;
    reg_amt_i     = v.ramt;
    operand_i     = v.op;
    carry_i       = v.cin;
    ovf_i         = ovf;
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk_i);
    check("R10 reset flags", {28'h0, flags_q_o}, 32'h0);
    rst_ni = 1'b1;

    // Table walk: R1-related distance selection, all kinds, flags R9
    for (int i = 0; i < NV; i++) begin
      @(negedge clk_i);
      drive(VECS[i], i[0]);
      #5;
      check($sformatf("R2..R8 result vec %0d", i), result_o, VECS[i].res);
      check($sformatf("R2..R8 carry vec %0d", i), {31'h0, nzcv_o[1]}, {31'h0, VECS[i].c});
      check($sformatf("R9 N vec %0d", i), {31'h0, nzcv_o[3]}, {31'h0, VECS[i].res[31]});
      check($sformatf("R9 Z vec %0d", i), {31'h0, nzcv_o[2]}, {31'h0, VECS[i].res == 32'h0});
      check($sformatf("R9 V vec %0d", i), {31'h0, nzcv_o[0]}, {31'h0, i[0]});
    end

    // R10 with R6: capture while zero distance passes carry_i
    @(negedge clk_i);
    drive('{2'd0, 1'b1, 5'd7, 32'h0000_0000, 32'h8000_0000, 1'b1, 32'h0, 1'b0}, 1'b1);
    flags_we_i = 1'b1;
    @(negedge clk_i);
    flags_we_i = 1'b0;
    check("R10 R6 captured flags", {28'h0, flags_q_o}, 32'hB);

    // R10 hold: inputs change without write enable
    drive('{2'd1, 1'b1, 5'd0, 32'd33, 32'hFFFF_FFFF, 1'b0, 32'h0, 1'b0}, 1'b0);
    @(negedge clk_i);
    check("R10 hold flags", {28'h0, flags_q_o}, 32'hB);

    // R10 with R7: capture at distance 33, result zero, carry 0
    flags_we_i = 1'b1;
    @(negedge clk_i);
    flags_we_i = 1'b0;
    check("R10 R7 captured flags", {28'h0, flags_q_o}, 32'h4);

    // R10 asynchronous reset clears flags
    #3 rst_ni = 1'b0;
    #2;
    check("R10 async reset", {28'h0, flags_q_o}, 32'h0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule